// File: doc/BRIEF.md
# Range-Tracking Register Hazard Table

This block keeps track of register writes that are still in flight for every warp of an in-order SIMT pipeline. There is no operand forwarding, so an instruction may only read or overwrite registers whose earlier writes have fully landed in the register file. Each pending write is stored as a compact range: a start register plus a register count. Each warp owns a fixed number of these range slots.

The issue stage presents a warp number, up to two source ranges and one destination range on the check port. The block answers in the same cycle with a stall flag, the reasons for it, and the slot that the destination would occupy. When the issue stage accepts an instruction that was not stalled, the destination range is recorded in the lowest free slot of that warp. When a write completes, the writeback port names the warp and slot, and that slot becomes free.

Top module: `region_scoreboard`

## Requirements
- R1: After reset every slot of every warp is free, so no check stalls and the offered slot (`chk_slot`) is 0.
- R2: A source range that shares at least one register with a recorded range of the same warp raises `chk_raw` and `chk_stall`.
- R3: A destination range that shares at least one register with a recorded range of the same warp raises `chk_war` and `chk_stall`.
- R4: Ranges [b1, b1+n1) and [b2, b2+n2) conflict only when b1 < b2+n2 and b2 < b1+n1, computed without wrap-around. Ranges that merely touch end to end do not conflict, including at the top of the register space.
- R5: A source or destination with a length of 0 is absent. It never conflicts, and a zero-length destination allocates nothing.
- R6: When every slot of a warp holds a range, `chk_full` and `chk_stall` are 1 for that warp, whatever the operands are.
- R7: With `issue_accept` high, `chk_stall` low and a non-zero destination length, the destination range is written into the lowest-numbered free slot. That slot is the one reported on `chk_slot`, and it takes part in checks from the next cycle on.
- R8: `issue_accept` while `chk_stall` is high records nothing.
- R9: A writeback (`wb_valid` with `wb_warp`, `wb_slot`) frees that slot from the next cycle on. It then no longer causes conflicts and can be offered again.
- R10: A writeback and an allocation in the same cycle both take effect.
- R11: Warps are independent. The ranges and fullness of one warp never affect checks for another warp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_warp | input | WARP_W | Warp being checked |
| chk_src_base | input | NUM_SRC*REG_W | Start registers of the sources; source k is in bits [k*REG_W +: REG_W] |
| chk_src_len | input | NUM_SRC*LEN_W | Source lengths; source k is in bits [k*LEN_W +: LEN_W]; 0 means absent |
| chk_dst_base | input | REG_W | Start register of the destination |
| chk_dst_len | input | LEN_W | Destination length; 0 means absent |
| issue_accept | input | 1 | Issue stage takes the checked instruction |
| wb_valid | input | 1 | A pending write has completed |
| wb_warp | input | WARP_W | Warp of the completed write |
| wb_slot | input | SLOT_W | Slot of the completed write |
| chk_stall | output | 1 | Instruction must wait |
| chk_raw | output | 1 | A source conflicts with a pending range |
| chk_war | output | 1 | The destination conflicts with a pending range |
| chk_full | output | 1 | All slots of the warp are occupied |
| chk_slot | output | SLOT_W | Lowest free slot, which the destination would take (0 when full) |

## Verification
The assertions assume that a writeback names a slot index below SLOTS. They also assume that `issue_accept` is only a request, so an accept during a stall must change nothing. The properties about freeing a slot assume that no allocation lands in the same warp in that cycle. The bench keeps to these assumptions: it writes back only slots it has itself seen allocated, and it changes inputs only between clock edges. Each scenario drives one warp at a time. It tracks the expected slot contents from the allocation order, and checks both the combinational answer and the state one cycle after each update.

// File: rtl/region_scoreboard.sv
module region_scoreboard #(
  parameter int NUM_WARPS = 8,
  parameter int SLOTS     = 6,
  parameter int REG_W     = 6,
  parameter int LEN_W     = 3,
  parameter int NUM_SRC   = 2,
  localparam int WARP_W   = $clog2(NUM_WARPS),
  localparam int SLOT_W   = $clog2(SLOTS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [WARP_W-1:0]          chk_warp,
  input  logic [NUM_SRC*REG_W-1:0]   chk_src_base,
  input  logic [NUM_SRC*LEN_W-1:0]   chk_src_len,
  input  logic [REG_W-1:0]           chk_dst_base,
  input  logic [LEN_W-1:0]           chk_dst_len,
  input  logic                       issue_accept,
  input  logic                       wb_valid,
  input  logic [WARP_W-1:0]          wb_warp,
  input  logic [SLOT_W-1:0]          wb_slot,
  output logic                       chk_stall,
  output logic                       chk_raw,
  output logic                       chk_war,
  output logic                       chk_full,
  output logic [SLOT_W-1:0]          chk_slot
);
  localparam int SUM_W = ((REG_W > LEN_W) ? REG_W : LEN_W) + 1;

  logic [SLOTS-1:0] vld_q  [NUM_WARPS];
  logic [REG_W-1:0] base_q [NUM_WARPS][SLOTS];
  logic [LEN_W-1:0] len_q  [NUM_WARPS][SLOTS];

  function automatic logic overlap(input logic [REG_W-1:0] b1, input logic [LEN_W-1:0] n1,
                                   input logic [REG_W-1:0] b2, input logic [LEN_W-1:0] n2);
    logic [SUM_W-1:0] lo1, hi1, lo2, hi2;
    lo1 = SUM_W'(b1);
    hi1 = SUM_W'(b1) + SUM_W'(n1);
    lo2 = SUM_W'(b2);
    hi2 = SUM_W'(b2) + SUM_W'(n2);
    return (n1 != '0) && (n2 != '0) && (lo1 < hi2) && (lo2 < hi1);
  endfunction

  logic [SLOTS-1:0] row_vld, src_hit, dst_hit;
  logic [SLOT_W-1:0] free_idx;
  logic alloc;

  assign row_vld = vld_q[chk_warp];

  always_comb begin
    src_hit = '0;
    dst_hit = '0;
    for (int s = 0; s < SLOTS; s++) begin
      for (int k = 0; k < NUM_SRC; k++)
        if (overlap(chk_src_base[k*REG_W +: REG_W], chk_src_len[k*LEN_W +: LEN_W],
                    base_q[chk_warp][s], len_q[chk_warp][s]))
          src_hit[s] = 1'b1;
      dst_hit[s] = overlap(chk_dst_base, chk_dst_len, base_q[chk_warp][s], len_q[chk_warp][s]);
    end
  end

  always_comb begin
    free_idx = '0;
    for (int s = SLOTS - 1; s >= 0; s--)
      if (!row_vld[s]) free_idx = SLOT_W'(s);
  end

  assign chk_raw   = |(row_vld & src_hit);
  assign chk_war   = |(row_vld & dst_hit);
  assign chk_full  = &row_vld;
  assign chk_stall = chk_raw | chk_war | chk_full;
  assign chk_slot  = free_idx;
  assign alloc     = issue_accept & ~chk_stall & (chk_dst_len != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < NUM_WARPS; w++) begin
        vld_q[w] <= '0;
        for (int s = 0; s < SLOTS; s++) begin
          base_q[w][s] <= '0;
          len_q[w][s]  <= '0;
        end
      end
    end else begin
      if (wb_valid && int'(wb_slot) < SLOTS)
        vld_q[wb_warp][wb_slot] <= 1'b0;
      if (alloc) begin
        vld_q[chk_warp][free_idx]  <= 1'b1;
        base_q[chk_warp][free_idx] <= chk_dst_base;
        len_q[chk_warp][free_idx]  <= chk_dst_len;
      end
    end
  end
endmodule

// File: rtl/region_scoreboard_chk.sv
module region_scoreboard_chk #(
  parameter int SLOTS  = 6,
  parameter int WARP_W = 3,
  parameter int SLOT_W = 3,
  parameter int LEN_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WARP_W-1:0] chk_warp,
  input logic [LEN_W-1:0]  chk_dst_len,
  input logic              issue_accept,
  input logic              wb_valid,
  input logic [WARP_W-1:0] wb_warp,
  input logic [SLOT_W-1:0] wb_slot,
  input logic              chk_stall,
  input logic              chk_raw,
  input logic              chk_war,
  input logic              chk_full,
  input logic [SLOT_W-1:0] chk_slot
);
  // R2
  raw_stall_chk: assert property (@(posedge clk) disable iff (!rst_n) chk_raw |-> chk_stall);
  // R3
  war_stall_chk: assert property (@(posedge clk) disable iff (!rst_n) chk_war |-> chk_stall);
  // R5
  absent_dst_chk: assert property (@(posedge clk) disable iff (!rst_n) (chk_dst_len == '0) |-> !chk_war);
  // R6
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n) chk_full |-> chk_stall);
  // R7
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n) !chk_full |-> (int'(chk_slot) < SLOTS));
  // R9
  wb_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && int'(wb_slot) < SLOTS && !(issue_accept && !chk_stall && chk_dst_len != '0))
    |=> (chk_warp != $past(wb_warp)) || !chk_full);
endmodule

bind region_scoreboard region_scoreboard_chk #(
  .SLOTS(SLOTS), .WARP_W(WARP_W), .SLOT_W(SLOT_W), .LEN_W(LEN_W)
) i_region_scoreboard_chk (
  .clk(clk), .rst_n(rst_n), .chk_warp(chk_warp), .chk_dst_len(chk_dst_len),
  .issue_accept(issue_accept), .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_slot(wb_slot),
  .chk_stall(chk_stall), .chk_raw(chk_raw), .chk_war(chk_war), .chk_full(chk_full),
  .chk_slot(chk_slot)
);

// File: tb/test_region_scoreboard.sv
module test_region_scoreboard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] chk_warp = '0;
  logic [11:0] chk_src_base = '0;
  logic [5:0] chk_src_len = '0;
  logic [5:0] chk_dst_base = '0;
  logic [2:0] chk_dst_len = '0;
  logic       issue_accept = 1'b0;
  logic       wb_valid = 1'b0;
  logic [2:0] wb_warp = '0;
  logic [2:0] wb_slot = '0;
  logic       chk_stall, chk_raw, chk_war, chk_full;
  logic [2:0] chk_slot;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  region_scoreboard i_region_scoreboard (
    .clk(clk), .rst_n(rst_n), .chk_warp(chk_warp), .chk_src_base(chk_src_base),
    .chk_src_len(chk_src_len), .chk_dst_base(chk_dst_base), .chk_dst_len(chk_dst_len),
    .issue_accept(issue_accept), .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_slot(wb_slot),
    .chk_stall(chk_stall), .chk_raw(chk_raw), .chk_war(chk_war), .chk_full(chk_full),
    .chk_slot(chk_slot)
  );

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic probe(int w, int s0b, int s0l, int s1b, int s1l, int db, int dl);
    @(negedge clk);
    chk_warp = 3'(w);
    chk_src_base = {6'(s1b), 6'(s0b)};
    chk_src_len = {3'(s1l), 3'(s0l)};
    chk_dst_base = 6'(db);
    chk_dst_len = 3'(dl);
    #1;
  endtask

  task automatic alloc(int w, int db, int dl, int exp_slot);
    probe(w, 0, 0, 0, 0, db, dl);
    check("R7 alloc no stall", chk_stall, 0);
    check("R7 offered slot", chk_slot, exp_slot);
    issue_accept = 1'b1;
    @(posedge clk);
    #1 issue_accept = 1'b0;
  endtask

  task automatic writeback(int w, int s);
    @(negedge clk);
    wb_valid = 1'b1; wb_warp = 3'(w); wb_slot = 3'(s);
    @(posedge clk);
    #1 wb_valid = 1'b0;
  endtask

  task automatic t_reset();
    for (int w = 0; w < 8; w++) begin
      probe(w, 5, 2, 9, 1, 3, 1);
      check("R1 stall after reset", chk_stall, 0);
      check("R1 slot after reset", chk_slot, 0);
    end
  endtask

  task automatic t_hazards();
    alloc(1, 10, 2, 0);
    probe(1, 0, 0, 0, 0, 11, 1);
    check("R3 war flag", chk_war, 1);
    check("R3 stall", chk_stall, 1);
    probe(1, 11, 1, 0, 0, 30, 1);
    check("R2 raw flag", chk_raw, 1);
    check("R2 stall", chk_stall, 1);
    probe(1, 0, 0, 9, 2, 30, 1);
    check("R2 second source raw", chk_raw, 1);
    probe(1, 12, 2, 8, 2, 30, 1);
    check("R4 touching ranges raw", chk_raw, 0);
    check("R4 touching ranges stall", chk_stall, 0);
    probe(1, 10, 0, 0, 0, 10, 0);
    check("R5 zero-length source", chk_raw, 0);
    check("R5 zero-length dest", chk_war, 0);
    alloc(1, 20, 1, 1);
    probe(1, 20, 1, 0, 0, 30, 1);
    check("R7 new region raw", chk_raw, 1);
    probe(1, 0, 0, 0, 0, 30, 1);
    check("R7 lowest free slot", chk_slot, 2);
  endtask

  task automatic t_stalled_accept();
    probe(1, 0, 0, 0, 0, 10, 1);
    check("R8 stalled", chk_stall, 1);
    issue_accept = 1'b1;
    @(posedge clk);
    #1 issue_accept = 1'b0;
    probe(1, 0, 0, 0, 0, 30, 1);
    check("R8 slot unchanged", chk_slot, 2);
    probe(1, 0, 0, 0, 0, 40, 0);
    issue_accept = 1'b1;
    @(posedge clk);
    #1 issue_accept = 1'b0;
    probe(1, 40, 1, 0, 0, 30, 1);
    check("R5 zero dest no region", chk_raw, 0);
    check("R5 zero dest slot unchanged", chk_slot, 2);
  endtask

  task automatic t_writeback();
    writeback(1, 0);
    probe(1, 10, 2, 0, 0, 30, 1);
    check("R9 freed range raw", chk_raw, 0);
    check("R9 freed slot offered", chk_slot, 0);
    probe(1, 20, 1, 0, 0, 30, 1);
    check("R9 other slot kept", chk_raw, 1);
  endtask

  task automatic t_full();
    for (int i = 0; i < 6; i++) alloc(2, i * 4, 1, i);
    probe(2, 0, 0, 0, 0, 60, 1);
    check("R6 full flag", chk_full, 1);
    check("R6 full stall", chk_stall, 1);
    probe(2, 0, 0, 0, 0, 0, 0);
    check("R6 stall without operands", chk_stall, 1);
    probe(3, 0, 1, 0, 0, 4, 1);
    check("R11 other warp not stalled", chk_stall, 0);
    check("R11 other warp slot", chk_slot, 0);
    writeback(2, 3);
    probe(2, 0, 0, 0, 0, 60, 1);
    check("R9 not full after wb", chk_full, 0);
    check("R9 freed slot", chk_slot, 3);
    alloc(2, 40, 1, 3);
  endtask

  task automatic t_same_cycle();
    writeback(2, 5);
    probe(2, 0, 0, 0, 0, 50, 1);
    check("R10 pre slot", chk_slot, 5);
    wb_valid = 1'b1; wb_warp = 3'd2; wb_slot = 3'd0;
    issue_accept = 1'b1;
    @(posedge clk);
    #1;
    wb_valid = 1'b0;
    issue_accept = 1'b0;
    probe(2, 50, 1, 0, 0, 60, 1);
    check("R10 allocated range raw", chk_raw, 1);
    probe(2, 0, 1, 0, 0, 60, 1);
    check("R10 released range raw", chk_raw, 0);
    check("R10 lowest free", chk_slot, 0);
    check("R10 not full", chk_full, 0);
  endtask

  task automatic t_top_edge();
    alloc(4, 62, 2, 0);
    probe(4, 63, 1, 0, 0, 10, 1);
    check("R4 top register raw", chk_raw, 1);
    probe(4, 60, 2, 0, 0, 10, 1);
    check("R4 touching below top", chk_raw, 0);
    probe(4, 0, 0, 0, 0, 61, 3);
    check("R4 dest spanning top", chk_war, 1);
    probe(4, 0, 2, 0, 0, 2, 1);
    check("R4 no wrap to low regs", chk_stall, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_hazards();
    t_stalled_accept();
    t_writeback();
    t_full();
    t_same_cycle();
    t_top_edge();
    finish_run();
  end
endmodule